// File: doc/BRIEF.md
# Parallel-Port FIFO with Service Interrupt

This block holds a sixteen-entry byte queue shared by every buffered transfer path of an extended parallel port (forward data, address/compression bytes and test loopback all use the same storage). A host reaches it through a small register bus. Address 0 is the queue window and address 1 is a control/status byte. The port engine sits on the other side and moves bytes through a push/pop interface. A direction input decides which side fills the queue and which side drains it. When direction is 0 the host writes and the engine drains. When direction is 1 the engine fills and the host reads.

The control byte carries a self-setting service flag. While software keeps the flag at 0, hardware raises it on one of two events. With DMA enabled, the event is the end of a DMA transfer. With DMA disabled, the event is enough free room (direction 0) or enough held data (direction 1). Raising the flag emits a one-cycle interrupt pulse. A flag value of 1 masks both the interrupt and the DMA request. Only a software write of 0 re-arms the flag, and a software write of 1 never produces a pulse. The DMA request is a level that depends on the enable, the flag, the direction and the queue's room or data.

Top module: `ppsvc_top`

## Requirements
- R1: Bytes leave the queue in the order they entered it, and up to DEPTH (16) bytes can be held.
- R2: Control byte bit 0 reads 1 exactly when the queue holds no bytes.
- R3: Control byte bit 1 reads 1 exactly when the queue holds DEPTH bytes.
- R4: A push while full and a pop while empty are ignored: the count and the stored bytes are unchanged.
- R5: With dir=0, a host write to address 0 pushes and a `per_pop` pops. With dir=1, a `per_push` pushes and a host read strobe at address 0 pops. Strobes from the other side are ignored.
- R6: After reset the queue is empty, the service flag is 1, the control byte reads 0x05, and `irq` and `dma_req` are 0.
- R7: With the DMA enable (bit 3) at 1 and the service flag at 0, a `dma_tc` pulse sets the service flag, and the thresholds are not used.
- R8: With DMA disabled and dir=0, the service flag sets when the free space is at least WR_THR (default 8).
- R9: With DMA disabled and dir=1, the service flag sets when the held byte count is at least RD_THR (default 8).
- R10: The service flag (bit 2) stays 1 until software writes 0 to it. A software write of 1 causes no `irq`.
- R11: Every hardware setting of the service flag gives exactly one `irq` pulse, one cycle wide, in the cycle after the setting condition was sampled.
- R12: `dma_req` is 1 only when the DMA enable is 1, the service flag is 0, and the queue has room (dir=0) or data (dir=1).
- R13: Control byte bits 7:5 (mode), bit 4 (active-low error-interrupt enable) and bit 3 (DMA enable) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 1 | Register select: 0 queue window, 1 control byte |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops at address 0 when dir=1) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data: queue head or control byte |
| dir | input | 1 | Transfer direction: 0 host to port, 1 port to host |
| per_push | input | 1 | Engine push strobe |
| per_din | input | 8 | Engine push data |
| per_pop | input | 1 | Engine pop strobe |
| per_dout | output | 8 | Queue head byte seen by the engine |
| dma_tc | input | 1 | DMA terminal-count pulse |
| irq | output | 1 | Service interrupt pulse |
| dma_req | output | 1 | DMA request level |

## Verification
The assertions check on every cycle that the service flag stays set until a control write, that `irq` is never longer than one cycle, and that it follows every hardware setting and never a software write of 1. They also check that `dma_req` is never raised while the flag masks it and that a blocked push or pop leaves the count unchanged. Only the bench scenarios can show the data order through the queue, the exact threshold edges (nine bytes held against eight free, seven held against eight held), the steering of strobes by direction, and the read-back of the mode and enable fields.

// File: rtl/ppsvc_pkg.sv
package ppsvc_pkg;

  // Control/status byte layout. The positions matter to software.
  typedef struct packed {
    logic [2:0] mode;     // 7:5
    logic       err_n;    // 4
    logic       dma_en;   // 3
    logic       svc;      // 2
    logic       full;     // 1
    logic       empty;    // 0
  } ctrl_byte_t;

  localparam logic ADDR_QUEUE = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;

  localparam logic DIR_OUT = 1'b0;
  localparam logic DIR_IN  = 1'b1;

endpackage

// File: rtl/ppsvc_fifo.sv
module ppsvc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign rdata = mem[rd_ptr_q];

  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = bump(wr_ptr_q);
    if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage: written only with an accepted push, no reset needed.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> $stable(cnt_q));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: rtl/ppsvc_steer.sv
module ppsvc_steer
  import ppsvc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         dir,
  input  logic         host_addr,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] host_wdata,
  input  logic         per_push,
  input  logic [W-1:0] per_din,
  input  logic         per_pop,
  output logic         q_push,
  output logic         q_pop,
  output logic [W-1:0] q_wdata,
  output logic         ctrl_wr
);

  logic host_q_wr, host_q_rd;

  always_comb begin
    host_q_wr = host_wr && (host_addr == ADDR_QUEUE);
    host_q_rd = host_rd && (host_addr == ADDR_QUEUE);
    ctrl_wr   = host_wr && (host_addr == ADDR_CTRL);
    if (dir == DIR_OUT) begin
      q_push  = host_q_wr;
      q_wdata = host_wdata;
      q_pop   = per_pop;
    end else begin
      q_push  = per_push;
      q_wdata = per_din;
      q_pop   = host_q_rd;
    end
  end

endmodule

// File: rtl/ppsvc_ctrl.sv
module ppsvc_ctrl
  import ppsvc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [7:0]       wdata,
  input  logic             dir,
  input  logic             dma_tc,
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic             empty,
  output logic [7:0]       ctrl_rd,
  output logic             irq,
  output logic             dma_req
);

  ctrl_byte_t       wr_view;
  logic [2:0]       mode_q, mode_d;
  logic             err_n_q, err_n_d;
  logic             dma_en_q, dma_en_d;
  logic             svc_q, svc_d;
  logic             irq_q, irq_d;
  logic             svc_cond;
  logic             hw_set;
  logic [CNT_W-1:0] free_cnt;
  ctrl_byte_t       rd_view;

  assign wr_view  = ctrl_byte_t'(wdata);
  assign free_cnt = CNT_W'(DEPTH) - count;

  // Service condition chosen by DMA enable and direction.
  always_comb begin
    if (dma_en_q)            svc_cond = dma_tc;
    else if (dir == DIR_OUT) svc_cond = (free_cnt >= CNT_W'(WR_THR));
    else                     svc_cond = (count >= CNT_W'(RD_THR));
  end

  always_comb begin
    mode_d   = mode_q;
    err_n_d  = err_n_q;
    dma_en_d = dma_en_q;
    svc_d    = svc_q;
    hw_set   = 1'b0;
    if (ctrl_wr) begin
      mode_d   = wr_view.mode;
      err_n_d  = wr_view.err_n;
      dma_en_d = wr_view.dma_en;
      svc_d    = wr_view.svc;
    end else if (!svc_q && svc_cond) begin
      svc_d  = 1'b1;
      hw_set = 1'b1;
    end
    irq_d = hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      err_n_q  <= 1'b0;
      dma_en_q <= 1'b0;
      svc_q    <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      err_n_q  <= err_n_d;
      dma_en_q <= dma_en_d;
      svc_q    <= svc_d;
      irq_q    <= irq_d;
    end
  end

  always_comb begin
    rd_view.mode   = mode_q;
    rd_view.err_n  = err_n_q;
    rd_view.dma_en = dma_en_q;
    rd_view.svc    = svc_q;
    rd_view.full   = full;
    rd_view.empty  = empty;
  end

  assign ctrl_rd = rd_view;
  assign irq     = irq_q;
  assign dma_req = dma_en_q && !svc_q && ((dir == DIR_OUT) ? !full : !empty);

  assert_svc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !ctrl_wr) |=> svc_q);

  assert_sw_one_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !irq);

  assert_irq_follows_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && svc_cond && !ctrl_wr) |=> (irq && svc_q));

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_dma_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en_q && !svc_q));

endmodule

// File: rtl/ppsvc_top.sv
module ppsvc_top
  import ppsvc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       dir,
  input  logic       per_push,
  input  logic [7:0] per_din,
  input  logic       per_pop,
  output logic [7:0] per_dout,
  input  logic       dma_tc,
  output logic       irq,
  output logic       dma_req
);

  localparam int W     = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             q_push, q_pop, ctrl_wr;
  logic [W-1:0]     q_wdata, q_rdata;
  logic [CNT_W-1:0] q_count;
  logic             q_full, q_empty;
  logic [7:0]       ctrl_rd;

  ppsvc_steer #(.W(W)) u_steer (
    .dir        (dir),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .per_push   (per_push),
    .per_din    (per_din),
    .per_pop    (per_pop),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .q_wdata    (q_wdata),
    .ctrl_wr    (ctrl_wr)
  );

  ppsvc_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .wdata (q_wdata),
    .rdata (q_rdata),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  ppsvc_ctrl #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .wdata   (host_wdata),
    .dir     (dir),
    .dma_tc  (dma_tc),
    .count   (q_count),
    .full    (q_full),
    .empty   (q_empty),
    .ctrl_rd (ctrl_rd),
    .irq     (irq),
    .dma_req (dma_req)
  );

  assign per_dout   = q_rdata;
  assign host_rdata = (host_addr == ADDR_CTRL) ? ctrl_rd : q_rdata;

endmodule

// File: tb/tb_ppsvc_top.sv
`timescale 1ns/1ps
module tb_ppsvc_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_addr, host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       dir, per_push, per_pop, dma_tc;
  logic [7:0] per_din, per_dout;
  logic       irq, dma_req;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;

  always #5 clk = ~clk;

  ppsvc_top dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dir(dir), .per_push(per_push), .per_din(per_din), .per_pop(per_pop),
    .per_dout(per_dout), .dma_tc(dma_tc), .irq(irq), .dma_req(dma_req)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FIAL-free note suppressed");
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic read_ctrl(output logic [7:0] v);
    @(negedge clk); host_addr = 1'b1; #1 v = host_rdata;
  endtask

  task automatic host_pop(output logic [7:0] v);
    @(negedge clk); host_addr = 1'b0; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    @(negedge clk); per_din = d; per_push = 1'b1;
    @(negedge clk); per_push = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] v);
    @(negedge clk); #1 v = per_dout; per_pop = 1'b1;
    @(negedge clk); per_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    read_ctrl(v);
    check("R6 ctrl", v, 8'h05);
    check("R6 irq", {7'd0, irq}, 8'h00);
    check("R6 dma_req", {7'd0, dma_req}, 8'h00);
  endtask

  task automatic t_fields;
    logic [7:0] v;
    int base = irq_cnt;
    host_write(1'b1, 8'hB4); read_ctrl(v);
    check("R13 mode/err", v, 8'hB5);
    host_write(1'b1, 8'hAC); read_ctrl(v);
    check("R13 dma_en", v, 8'hAD);
    #1 check("R12 masked by svc", {7'd0, dma_req}, 8'h00);
    host_write(1'b1, 8'h04); read_ctrl(v);
    check("R13 restore", v, 8'h05);
    check("R10 write one quiet", 8'(irq_cnt - base), 8'h00);
  endtask

  task automatic t_order;
    logic [7:0] v;
    dir = 1'b0;
    for (int i = 0; i < 16; i++) begin
      host_write(1'b0, 8'h30 + 8'(i));
      if (i == 0)  begin read_ctrl(v); check("R2 not empty", v, 8'h04); end
      if (i == 14) begin read_ctrl(v); check("R3 not full at 15", v, 8'h04); end
    end
    read_ctrl(v); check("R3 full", v, 8'h06);
    host_write(1'b0, 8'hEE);
    read_ctrl(v); check("R4 push on full", v, 8'h06);
    for (int i = 0; i < 16; i++) begin
      eng_pop(v);
      check("R1 order", v, 8'h30 + 8'(i));
    end
    read_ctrl(v); check("R2 empty", v, 8'h05);
    eng_pop(v);
    host_write(1'b0, 8'h77);
    #1 check("R4 pop on empty", per_dout, 8'h77);
    read_ctrl(v); check("R4 one held", v, 8'h04);
    eng_pop(v);
  endtask

  task automatic t_steer;
    logic [7:0] v;
    dir = 1'b0;
    eng_push(8'h55);
    read_ctrl(v); check("R5 engine push ignored dir0", v, 8'h05);
    @(negedge clk); dir = 1'b1;
    host_write(1'b0, 8'h66);
    read_ctrl(v); check("R5 host write ignored dir1", v, 8'h05);
    eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
    eng_pop(v);
    host_pop(v); check("R5 engine pop ignored dir1", v, 8'h11);
    host_pop(v); check("R5 host pop", v, 8'h22);
    host_pop(v); check("R5 host pop", v, 8'h33);
    read_ctrl(v); check("R5 drained", v, 8'h05);
  endtask

  task automatic t_wr_thr;
    logic [7:0] v;
    int base;
    @(negedge clk); dir = 1'b0;
    for (int i = 0; i < 9; i++) host_write(1'b0, 8'(i));
    base = irq_cnt;
    host_write(1'b1, 8'h00);
    idle(4);
    read_ctrl(v); check("R8 seven free no set", v, 8'h00);
    check("R8 no irq", 8'(irq_cnt - base), 8'h00);
    eng_pop(v);
    idle(2);
    read_ctrl(v); check("R8 eight free sets", v, 8'h04);
    check("R11 one pulse", 8'(irq_cnt - base), 8'h01);
    for (int i = 0; i < 8; i++) eng_pop(v);
  endtask

  task automatic t_rd_thr;
    logic [7:0] v;
    int base;
    @(negedge clk); dir = 1'b1;
    base = irq_cnt;
    host_write(1'b1, 8'h00);
    idle(2);
    read_ctrl(v); check("R9 empty armed", v, 8'h01);
    for (int i = 0; i < 7; i++) eng_push(8'hA0 + 8'(i));
    idle(2);
    read_ctrl(v); check("R9 seven held no set", v, 8'h00);
    check("R9 no irq", 8'(irq_cnt - base), 8'h00);
    eng_push(8'hA7);
    idle(2);
    read_ctrl(v); check("R9 eight held sets", v, 8'h04);
    check("R11 one pulse", 8'(irq_cnt - base), 8'h01);
    for (int i = 0; i < 8; i++) host_pop(v);
    idle(2);
    read_ctrl(v); check("R10 sticky", v, 8'h05);
  endtask

  task automatic t_sw_one;
    logic [7:0] v;
    int base = irq_cnt;
    host_write(1'b1, 8'h00);
    idle(3);
    read_ctrl(v); check("R10 armed", v, 8'h01);
    host_write(1'b1, 8'h04);
    idle(2);
    read_ctrl(v); check("R10 sw one sets", v, 8'h05);
    check("R10 sw one no irq", 8'(irq_cnt - base), 8'h00);
  endtask

  task automatic t_dma;
    logic [7:0] v;
    int base;
    @(negedge clk); dir = 1'b0;
    base = irq_cnt;
    host_write(1'b1, 8'h08);
    idle(3);
    read_ctrl(v); check("R7 threshold unused", v, 8'h09);
    #1 check("R12 room", {7'd0, dma_req}, 8'h01);
    for (int i = 0; i < 16; i++) host_write(1'b0, 8'(i));
    #1 check("R12 full blocks", {7'd0, dma_req}, 8'h00);
    eng_pop(v);
    #1 check("R12 room again", {7'd0, dma_req}, 8'h01);
    @(negedge clk); dma_tc = 1'b1;
    @(negedge clk); dma_tc = 1'b0;
    idle(1);
    read_ctrl(v); check("R7 tc sets", v, 8'h0C);
    check("R7 irq", 8'(irq_cnt - base), 8'h01);
    #1 check("R12 svc masks", {7'd0, dma_req}, 8'h00);
    for (int i = 0; i < 15; i++) eng_pop(v);
    @(negedge clk); dir = 1'b1;
    host_write(1'b1, 8'h08);
    #1 check("R12 no data", {7'd0, dma_req}, 8'h00);
    eng_push(8'h5A);
    #1 check("R12 data", {7'd0, dma_req}, 8'h01);
    @(negedge clk); dma_tc = 1'b1;
    @(negedge clk); dma_tc = 1'b0;
    idle(1);
    read_ctrl(v); check("R7 tc sets dir1", v, 8'h0C);
    check("R7 irq dir1", 8'(irq_cnt - base), 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: R1 run did not finish, actual timeout expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = 8'h00; dir = 1'b0; per_push = 1'b0; per_din = 8'h00;
    per_pop = 1'b0; dma_tc = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fields;
    t_order;
    t_steer;
    t_wr_thr;
    t_rd_thr;
    t_sw_one;
    t_dma;
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule